// File: doc/BRIEF.md
# NAK Timeout Frame Monitor

A host-side watchdog for one endpoint. It counts consecutive frames (or microframes at high speed) in which the endpoint got nothing but NAK handshakes back. When that run grows longer than a programmed window, the monitor does three things:

- it halts the endpoint;
- it raises a sticky timeout flag;
- it emits a single-cycle interrupt pulse.

The endpoint stays halted until the CPU clears the flag.

The window is programmed as an exponent. A 5-bit limit value `m` selects a window of 2^(m-1) frames. Values below 2 switch the watchdog off. The frame tick and the transaction scheduler are outside this block. The scheduler reports handshakes through two strobes and marks with a level when a transaction on this endpoint is in progress.

Top module: `nak_timeout_mon`

## Requirements
- R1: After reset, `halt_o`, `timeout_o` and `irq_o` are 0.
- R2: With limit `m` in 2..16, the window is W = 2^(m-1). `timeout_o` and `halt_o` become 1 on the frame tick that closes the (W+1)th consecutive NAK frame. After W such frames they are still 0.
- R3: A limit of 0 or 1 disables the watchdog. No number of NAK frames sets the flag.
- R4: Limit values 17 to 31 behave exactly like 16 (window 32768 frames).
- R5: A non-NAK response (`resp_other_i`) accepted while a transaction is active clears the NAK frame count and any NAK already seen in the current frame. A NAK in the same cycle is discarded.
- R6: The count advances by at most one per frame tick, however many NAKs the frame held. A frame tick closing a frame with no NAK neither advances nor clears the count.
- R7: A NAK strobe in the same cycle as the frame tick counts toward the frame that tick closes.
- R8: NAK and non-NAK strobes are ignored while `xact_active_i` is 0.
- R9: Once set, `timeout_o` and `halt_o` hold through any further ticks and strobes until `flag_clr_i`. The clear also zeroes the count, so a full W+1 NAK frames are needed to time out again.
- R10: `irq_o` is high for exactly the one cycle in which `timeout_o` first reads 1. It does not pulse again while the flag stays set.
- R11: When `flag_clr_i` arrives in the same cycle as the tick that would set the flag, the clear wins. The flag stays 0 and the count restarts from zero.
- R12: The comparison uses the limit present at each tick. Lowering the limit below the count already reached sets the flag at the next NAK frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| limit_i | input | 5 | Timeout exponent m; window 2^(m-1) frames |
| frame_tick_i | input | 1 | One-cycle strobe at each frame/microframe boundary |
| nak_i | input | 1 | One-cycle strobe: NAK handshake received |
| resp_other_i | input | 1 | One-cycle strobe: any non-NAK response received |
| xact_active_i | input | 1 | Level: a transaction on this endpoint is in progress |
| flag_clr_i | input | 1 | CPU clear of the timeout flag |
| halt_o | output | 1 | Endpoint halted |
| timeout_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | One-cycle interrupt pulse on flag set |

## Verification
Every limit value from 0 to 17 is driven with an unbroken run of single-cycle NAK frames, each NAK coinciding with its tick. This locates the exact frame at which each window closes and separates the disabled, normal and clamped settings. Shorter directed runs add the following patterns:
- non-NAK responses mid-run, which separate a count reset from a hold;
- empty frames, which separate a hold from a reset;
- frames with several NAKs, which separate per-frame from per-strobe counting;
- NAKs while the transaction level is low;
- a clear coinciding with the terminal tick;
- a limit lowered part-way through a run.

The interrupt is sampled in the set cycle and in the cycle after it, and ticks continue after the flag is set, to show the pulse does not repeat.

// File: rtl/nak_timeout_mon.sv
module nak_timeout_mon #(
  parameter int LIM_W   = 5,
  parameter int MAX_EXP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             frame_tick_i,
  input  logic             nak_i,
  input  logic             resp_other_i,
  input  logic             xact_active_i,
  input  logic             flag_clr_i,
  output logic             halt_o,
  output logic             timeout_o,
  output logic             irq_o
);

  localparam int CNT_W = MAX_EXP;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             flag_q;
  logic             irq_q;

  logic [LIM_W-1:0] m_eff;
  logic             enabled;
  logic [CNT_W:0]   window;
  logic             accept;
  logic             nak_ok;
  logic             other_ok;
  logic             frame_nak;
  logic [CNT_W-1:0] cnt_inc;
  logic             set_now;

  assign m_eff     = (limit_i > LIM_W'(MAX_EXP)) ? LIM_W'(MAX_EXP) : limit_i;
  assign enabled   = (m_eff >= LIM_W'(2));
  assign window    = (CNT_W+1)'(1) << (m_eff - LIM_W'(1));
  assign accept    = xact_active_i & ~flag_q;
  assign nak_ok    = nak_i & accept;
  assign other_ok  = resp_other_i & accept;
  assign frame_nak = pend_q | nak_ok;
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  assign set_now   = ~flag_clr_i & ~other_ok & frame_tick_i & enabled &
                     frame_nak & ~flag_q & ({1'b0, cnt_inc} > window);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= set_now;
      if (flag_clr_i) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
        flag_q <= 1'b0;
      end else if (other_ok) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else if (frame_tick_i) begin
        pend_q <= 1'b0;
        if (!enabled)
          cnt_q <= '0;
        else if (frame_nak)
          cnt_q <= cnt_inc;
        if (set_now)
          flag_q <= 1'b1;
      end else if (nak_ok) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign halt_o    = flag_q;
  assign timeout_o = flag_q;
  assign irq_o     = irq_q;

endmodule

module nak_timeout_mon_chk #(
  parameter int LIM_W = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LIM_W-1:0] limit_i,
  input logic             frame_tick_i,
  input logic             resp_other_i,
  input logic             xact_active_i,
  input logic             flag_clr_i,
  input logic             timeout_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt
);

  p_irq_with_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> timeout_o);

  p_rise_gives_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> irq_o);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(frame_tick_i));

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i < LIM_W'(2) && !timeout_o) |=> !timeout_o);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !flag_clr_i) |=> timeout_o);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i |=> (!timeout_o && cnt == '0));

  p_other_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_other_i && xact_active_i && !timeout_o) |=> cnt == '0);

  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick_i && !flag_clr_i && !resp_other_i) |=> $stable(cnt));

endmodule

bind nak_timeout_mon nak_timeout_mon_chk #(.LIM_W(LIM_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .limit_i(limit_i), .frame_tick_i(frame_tick_i),
  .resp_other_i(resp_other_i), .xact_active_i(xact_active_i),
  .flag_clr_i(flag_clr_i), .timeout_o(timeout_o), .irq_o(irq_o), .cnt(cnt_q)
);

// File: tb/nak_timeout_mon_test.sv
`timescale 1ns/1ps
module nak_timeout_mon_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] limit = '0;
  logic tick = 0, nak = 0, oth = 0, act = 1, clr = 0;
  logic halt, tmo, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nak_timeout_mon uut (
    .clk(clk), .rst_n(rst_n), .limit_i(limit), .frame_tick_i(tick),
    .nak_i(nak), .resp_other_i(oth), .xact_active_i(act), .flag_clr_i(clr),
    .halt_o(halt), .timeout_o(tmo), .irq_o(irq)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input bit t, input bit n, input bit o, input bit c);
    tick = t; nak = n; oth = o; clr = c;
    @(negedge clk);
    tick = 0; nak = 0; oth = 0; clr = 0;
  endtask

  task automatic frames(input int k);
    for (int i = 0; i < k; i++) cyc(1, 1, 0, 0);
  endtask

  task automatic clear();
    cyc(0, 0, 0, 1);
  endtask

  initial begin
    #1_400_000;
    fails++; tests++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 timeout", tmo, 0); chk("R1 halt", halt, 0); chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3 / R4 sweep of every limit value 0..17
    for (int m = 0; m <= 17; m++) begin
      int me, w;
      limit = 5'(m);
      clear();
      me = (m > 16) ? 16 : m;
      if (me < 2) begin
        frames(40);
        chk("R3 disabled", tmo, 0);
      end else begin
        w = 1 << (me - 1);
        frames(w);
        chk(m > 16 ? "R4 before window" : "R2 before window", tmo, 0);
        frames(1);
        chk(m > 16 ? "R4 at window" : "R2 at window", tmo, 1);
        chk("R2 halt", halt, 1);
        chk("R10 irq set cycle", irq, 1);
        cyc(0, 0, 0, 0);
        chk("R10 irq next cycle", irq, 0);
      end
    end

    // R9: sticky, no repeat pulse, clear restarts full window
    limit = 5'd3;
    clear();
    frames(5);
    chk("R9 set", tmo, 1);
    frames(6);
    chk("R9 held", tmo, 1);
    chk("R10 no repeat", irq, 0);
    cyc(0, 0, 1, 0);
    chk("R9 held after response", halt, 1);
    clear();
    chk("R9 cleared", tmo, 0);
    frames(4);
    chk("R9 full window again", tmo, 0);
    frames(1);
    chk("R9 times out again", tmo, 1);

    // R5: non-NAK response resets, same-cycle NAK discarded
    clear();
    frames(3);
    cyc(0, 1, 1, 0);
    cyc(1, 0, 0, 0);
    frames(4);
    chk("R5 reset count", tmo, 0);
    frames(1);
    chk("R5 after reset", tmo, 1);

    // R6: empty frames hold, many NAKs count once
    limit = 5'd2;
    clear();
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    chk("R6 two frames", tmo, 0);
    cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    chk("R6 third frame", tmo, 1);

    // R7: NAK on tick counts for the closing frame
    clear();
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    chk("R7 two", tmo, 0);
    cyc(1, 1, 0, 0);
    chk("R7 three", tmo, 1);

    // R8: strobes ignored when inactive
    clear();
    frames(2);
    act = 0;
    frames(5);
    cyc(0, 0, 1, 0);
    chk("R8 NAK ignored", tmo, 0);
    act = 1;
    frames(1);
    chk("R8 response ignored", tmo, 1);

    // R11: clear on the terminal tick wins
    clear();
    frames(2);
    cyc(1, 1, 0, 1);
    chk("R11 clear wins", tmo, 0);
    chk("R11 no irq", irq, 0);
    frames(2);
    chk("R11 count restarted", tmo, 0);
    frames(1);
    chk("R11 later set", tmo, 1);

    // R12: lowering the limit mid-run
    limit = 5'd5;
    clear();
    frames(10);
    chk("R12 under 16", tmo, 0);
    limit = 5'd2;
    cyc(1, 0, 0, 0);
    chk("R12 empty frame", tmo, 0);
    frames(1);
    chk("R12 lowered limit", tmo, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule